// File: doc/BRIEF.md
# Window-Clamped Signed Adder

This block adds two signed two's-complement operands and forces the result into a window whose lower and upper edges are supplied at run time. The addition is done one bit wider than the operands, so the true sum is known exactly and never wraps. That true sum is then compared against both edges. The clamped value is driven out, together with a two-bit code that says which edge, if any, was applied.

The block is purely combinational. It has no clock, no registers and no reset, so its outputs follow its inputs in the same cycle. A typical use is inside a datapath stage, limiting an accumulated amplitude or offset to a range that software can move. When the window is inverted, with the lower edge above the upper edge, the upper-edge test wins.

Top module: `satclamp_adder`

## Requirements
- R1: The operands are summed at WIDTH+1 bits with no wraparound. A true sum outside the WIDTH-bit range (for example 7+7=14 at WIDTH=4) is never folded back into range before the limit tests.
- R2: When the true sum is less than `lim_lo` and not greater than `lim_hi`, `sum_o` equals `lim_lo` and `clip_o` equals 1.
- R3: When the true sum is greater than `lim_hi`, `sum_o` equals `lim_hi` and `clip_o` equals 2.
- R4: When `lim_lo` <= true sum <= `lim_hi`, `sum_o` equals the true sum and `clip_o` equals 0.
- R5: With an inverted window (`lim_lo` > `lim_hi`) and a sum that violates both edges, the upper edge wins: `sum_o` equals `lim_hi` and `clip_o` equals 2.
- R6: `clip_o` never takes the value 3.
- R7: At WIDTH=4, the outputs are correct for every operand pair in -8..7 with each edge taking each of the values -8, 0, 1 and 7, in all sixteen edge combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First signed operand |
| opnd_b | input | WIDTH | Second signed operand |
| lim_lo | input | WIDTH | Signed lower edge of the window |
| lim_hi | input | WIDTH | Signed upper edge of the window |
| sum_o | output | WIDTH | Clamped signed sum |
| clip_o | output | 2 | 0 = in window, 1 = lower edge applied, 2 = upper edge applied |

## Verification
The hardest case to reach is an inverted window in which the true sum lies above the upper edge and below the lower edge at the same time. Only this case separates the precedence rule from an ordering in which the lower edge is tested first. The stimulus reaches it by sweeping every edge pairing from the set {-8, 0, 1, 7}, which includes the inverted pairs, against the full operand square. This also covers sums such as -16 and 14, which need the extra bit.

// File: rtl/satclamp_pkg.sv
package satclamp_pkg;

  typedef enum logic [1:0] {
    CLIP_NONE = 2'd0,
    CLIP_LO   = 2'd1,
    CLIP_HI   = 2'd2
  } clip_code_e;

endpackage

// File: rtl/sc_wide_add.sv
module sc_wide_add #(
  parameter int WIDTH = 4
) (
  input  logic signed [WIDTH-1:0] a_i,
  input  logic signed [WIDTH-1:0] b_i,
  output logic signed [WIDTH:0]   sum_o
);

  function automatic logic signed [WIDTH:0] grow(input logic signed [WIDTH-1:0] v);
    return {v[WIDTH-1], v};
  endfunction

  function automatic logic signed [WIDTH:0] add_exact(input logic signed [WIDTH-1:0] x,
                                                      input logic signed [WIDTH-1:0] y);
    return grow(x) + grow(y);
  endfunction

  always_comb sum_o = add_exact(a_i, b_i);

endmodule

// File: rtl/sc_limit_cmp.sv
module sc_limit_cmp #(
  parameter int WIDTH = 4,
  parameter bit ABOVE = 1'b0
) (
  input  logic signed [WIDTH:0]   sum_i,
  input  logic signed [WIDTH-1:0] lim_i,
  output logic                    hit_o
);

  function automatic logic signed [WIDTH:0] grow(input logic signed [WIDTH-1:0] v);
    return {v[WIDTH-1], v};
  endfunction

  generate
    if (ABOVE) begin : g_above
      always_comb hit_o = (sum_i > grow(lim_i));
    end else begin : g_below
      always_comb hit_o = (sum_i < grow(lim_i));
    end
  endgenerate

endmodule

// File: rtl/sc_select.sv
module sc_select
  import satclamp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic signed [WIDTH:0]   sum_i,
  input  logic signed [WIDTH-1:0] lo_i,
  input  logic signed [WIDTH-1:0] hi_i,
  input  logic                    hit_lo_i,
  input  logic                    hit_hi_i,
  output logic signed [WIDTH-1:0] y_o,
  output logic [1:0]              code_o
);

  function automatic logic signed [WIDTH-1:0] narrow(input logic signed [WIDTH:0] v);
    return v[WIDTH-1:0];
  endfunction

  always_comb begin
    if (hit_hi_i) begin
      y_o    = hi_i;
      code_o = CLIP_HI;
    end else if (hit_lo_i) begin
      y_o    = lo_i;
      code_o = CLIP_LO;
    end else begin
      y_o    = narrow(sum_i);
      code_o = CLIP_NONE;
    end
  end

endmodule

// File: rtl/satclamp_adder.sv
module satclamp_adder #(
  parameter int WIDTH = 4
) (
  input  logic signed [WIDTH-1:0] opnd_a,
  input  logic signed [WIDTH-1:0] opnd_b,
  input  logic signed [WIDTH-1:0] lim_lo,
  input  logic signed [WIDTH-1:0] lim_hi,
  output logic signed [WIDTH-1:0] sum_o,
  output logic [1:0]              clip_o
);

  localparam int WIDE = WIDTH + 1;

  logic signed [WIDE-1:0] exact_sum;
  logic                   under_lo;
  logic                   over_hi;

  sc_wide_add #(.WIDTH(WIDTH)) add_i (
    .a_i  (opnd_a),
    .b_i  (opnd_b),
    .sum_o(exact_sum)
  );

  sc_limit_cmp #(.WIDTH(WIDTH), .ABOVE(1'b0)) cmp_lo_i (
    .sum_i(exact_sum),
    .lim_i(lim_lo),
    .hit_o(under_lo)
  );

  sc_limit_cmp #(.WIDTH(WIDTH), .ABOVE(1'b1)) cmp_hi_i (
    .sum_i(exact_sum),
    .lim_i(lim_hi),
    .hit_o(over_hi)
  );

  sc_select #(.WIDTH(WIDTH)) sel_i (
    .sum_i   (exact_sum),
    .lo_i    (lim_lo),
    .hi_i    (lim_hi),
    .hit_lo_i(under_lo),
    .hit_hi_i(over_hi),
    .y_o     (sum_o),
    .code_o  (clip_o)
  );

endmodule

// File: rtl/satclamp_adder_chk.sv
module satclamp_adder_chk #(
  parameter int WIDTH = 4
) (
  input logic signed [WIDTH-1:0] opnd_a,
  input logic signed [WIDTH-1:0] opnd_b,
  input logic signed [WIDTH-1:0] lim_lo,
  input logic signed [WIDTH-1:0] lim_hi,
  input logic signed [WIDTH-1:0] sum_o,
  input logic [1:0]              clip_o,
  input logic signed [WIDTH:0]   exact_sum,
  input logic                    over_hi
);

  int ia, ib, ilo, ihi, isum, iout;

  always_comb begin
    ia   = int'(opnd_a);
    ib   = int'(opnd_b);
    ilo  = int'(lim_lo);
    ihi  = int'(lim_hi);
    isum = int'(exact_sum);
    iout = int'(sum_o);
    AST_EXACT_SUM: assert (isum == ia + ib) else $error("wide sum wrong"); // R1
    AST_LO_VALUE: assert (clip_o != 2'd1 || (iout == ilo && isum < ilo && isum <= ihi)) else $error("lower clamp wrong"); // R2
    AST_HI_VALUE: assert (clip_o != 2'd2 || (iout == ihi && isum > ihi)) else $error("upper clamp wrong"); // R3
    AST_PASS_THROUGH: assert (clip_o != 2'd0 || (iout == isum && isum >= ilo && isum <= ihi)) else $error("pass value wrong"); // R4
    AST_HI_WINS: assert (!over_hi || clip_o == 2'd2) else $error("upper edge lost priority"); // R5
    AST_CODE_LEGAL: assert (clip_o != 2'd3) else $error("illegal clip code"); // R6
  end

endmodule

bind satclamp_adder satclamp_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .lim_lo   (lim_lo),
  .lim_hi   (lim_hi),
  .sum_o    (sum_o),
  .clip_o   (clip_o),
  .exact_sum(exact_sum),
  .over_hi  (over_hi)
);

// File: tb/satclamp_adder_tb_top.sv
module satclamp_adder_tb_top;

  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic signed [W-1:0] a, b, lo, hi, y;
  logic [1:0]          code;

  satclamp_adder #(.WIDTH(W)) dut_i (
    .opnd_a(a), .opnd_b(b), .lim_lo(lo), .lim_hi(hi),
    .sum_o(y), .clip_o(code)
  );

  typedef struct {
    int    exp_y;
    int    exp_c;
    string tag;
  } item_t;

  item_t sbq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    drv_done = 1'b0;

  task automatic push(input int va, input int vb, input int vlo, input int vhi);
    item_t it;
    int    s;
    @(posedge clk);
    #1;
    a  = W'(va);
    b  = W'(vb);
    lo = W'(vlo);
    hi = W'(vhi);
    s  = va + vb;
    if (s > vhi) begin
      it.exp_y = vhi; it.exp_c = 2;
      it.tag = (s < vlo) ? "R5" : "R3";
    end else if (s < vlo) begin
      it.exp_y = vlo; it.exp_c = 1; it.tag = "R2";
    end else begin
      it.exp_y = s; it.exp_c = 0; it.tag = "R4";
    end
    if (s > 7 || s < -8) it.tag = {it.tag, "/R1"};
    sbq.push_back(it);
  endtask

  // monitor: samples on the falling edge, half a cycle after the driver
  always @(negedge clk) begin
    if (rst_n && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      n_chk++;
      if (int'(y) != it.exp_y || int'(code) != it.exp_c) begin
        n_bad++;
        $display("FAIL %s R7: a=%0d b=%0d lo=%0d hi=%0d got y=%0d c=%0d exp y=%0d c=%0d",
                 it.tag, a, b, lo, hi, y, code, it.exp_y, it.exp_c);
      end
      n_chk++;
      if (code == 2'd3) begin
        n_bad++;
        $display("FAIL R6: got c=%0d exp c!=3", code);
      end
    end
  end

  int lims[4] = '{-8, 0, 1, 7};

  initial begin
    a = '0; b = '0; lo = '0; hi = '0;
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if (y !== '0 || code !== 2'd0) begin
      n_bad++;
      $display("FAIL R4 reset state: got y=%0d c=%0d exp y=0 c=0", y, code);
    end
    rst_n = 1'b1;
    // directed corners
    push(7, 7, -8, 7);    // R1: 14 must clamp high, not wrap
    push(-8, -8, -8, 7);  // R1: -16 must clamp low
    push(3, 2, 7, -8);    // R5: inverted window, both violated
    push(-8, -8, 7, -8);  // R2 path under inverted window
    push(0, 1, 1, 1);     // R4: single-point window
    // R7 exhaustive sweep
    for (int il = 0; il < 4; il++)
      for (int ih = 0; ih < 4; ih++)
        for (int va = -8; va < 8; va++)
          for (int vb = -8; vb < 8; vb++)
            push(va, vb, lims[il], lims[ih]);
    @(posedge clk);
    @(posedge clk);
    drv_done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (drv_done && sbq.size() == 0);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule